// File: doc/BRIEF.md
# Hardware-Sequenced Flash Cycle Engine

This block lets a host run complete serial-flash operations through a few memory-mapped registers instead of driving opcodes on the wire itself. Software loads a 25-bit flash linear address, picks a cycle kind (read, write or block erase) and a byte count, and sets a go bit. The engine then runs the whole cycle alone. Each byte moves through a request/acknowledge port into a flash model or a SPI master. Data passes through a bank of 32-bit data words. The result appears as sticky done and error flags, which software clears by writing ones.

A cycle moves 1 to 64 bytes and must stay inside one 256-byte page. A cycle that would cross a page boundary is refused with an error, and no flash access is made. An erase ignores the byte count and erases the whole block that holds the address. The block size comes from a 2-bit strap that is shown in the status register. Only one cycle runs at a time. While it runs, the register file is frozen against host writes, except for the flag-clear writes.

Top module: `flc_engine`

## Requirements
- R1: Word 0 is the control register. Bit 0 is go and always reads 0. Bits 2:1 hold the cycle kind: 0 read, 1 reserved, 2 write, 3 erase. Bits 13:8 hold the byte count minus one. A control write while idle stores both fields, and they read back unchanged.
- R2: Writing control with bit 0 set while idle starts a cycle. Busy (status word 1, bit 2) reads 1 from the next clock until the cycle ends, and flash requests happen only while busy.
- R3: A read cycle of N bytes at address A fetches flash bytes A..A+N-1 in ascending order. Byte i is stored in bits 8*(i%4)+7:8*(i%4) of data word 4+i/4. Data bytes at i >= N keep their old value.
- R4: A write cycle of N bytes at address A sends data-bank byte i to flash address A+i, with the same byte packing as R3, in ascending order. It holds each request with a stable address until it is acknowledged.
- R5: An erase cycle makes exactly one flash request, whatever the byte count. Its address is A with the low bits cleared for the block size. The size comes from the strap input, which status bits 4:3 reflect: code 0, 1, 2, 3 means 256 B, 4 KiB, 8 KiB, 64 KiB.
- R6: A successful cycle sets done (status bit 0). A failed cycle sets error (status bit 1). One cycle never sets both.
- R7: The done and error flags are sticky. Writing 1 to a flag bit of status clears that flag, and writing 0 leaves it set. Writing back the value just read clears every set flag.
- R8: While busy, host writes to the control, address and data words are ignored, including a second go. The running cycle is not disturbed.
- R9: A read or write whose (A mod 256) + count - 1 exceeds 255 ends with error and makes no flash request. A cycle that ends exactly on byte 255 of the page runs normally.
- R10: The address register (word 2) stores all 32 bits. Only bits 24:0 reach the flash port. Bits 31:25 read back unchanged and are never altered by a cycle.
- R11: Cycle code 1 ends with error and makes no flash request.
- R12: If the flash signals an error on an acknowledge, the cycle ends there with error. No later byte is requested, and that byte of a read is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 5 | Register word address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| blk_code_i | input | 2 | Erase block size code strap |
| fl_req_o | output | 1 | Flash byte or erase request |
| fl_op_o | output | 2 | Cycle kind of the request |
| fl_addr_o | output | 25 | Flash linear address of the request |
| fl_wdata_o | output | 8 | Write byte |
| fl_ack_i | input | 1 | Flash acknowledge, one per request |
| fl_rdata_i | input | 8 | Read byte, valid with acknowledge |
| fl_err_i | input | 1 | Flash error, valid with acknowledge |

## Verification
The assertions assume that the flash side acknowledges only while a request is raised, that it never acknowledges the same request twice, and that the block-size strap is held steady for the whole of an erase cycle. The bench flash model answers each request one clock after it appears and then drops acknowledge for a cycle. The strap is changed only while the engine is idle. Error injection is a flag on a single address that the bench arms before a cycle starts.

// File: rtl/flc_pkg.sv
package flc_pkg;
  localparam int FLA_W = 25;

  typedef enum logic [1:0] {
    CYC_READ  = 2'd0,
    CYC_RSVD  = 2'd1,
    CYC_WRITE = 2'd2,
    CYC_ERASE = 2'd3
  } cyc_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_XFER,
    S_ERASE,
    S_FAIL
  } seq_st_e;

  // register word offsets
  localparam int CTRL_OFF = 0;
  localparam int STAT_OFF = 1;
  localparam int ADDR_OFF = 2;
  localparam int DATA_OFF = 4;

  // field positions
  localparam int GO_BIT   = 0;
  localparam int CYC_LSB  = 1;
  localparam int CNT_LSB  = 8;
  localparam int DONE_BIT = 0;
  localparam int ERR_BIT  = 1;
  localparam int BUSY_BIT = 2;
  localparam int BLK_LSB  = 3;

  // keeps the address bits above the erase block
  function automatic logic [FLA_W-1:0] blk_keep(input logic [1:0] code);
    logic [FLA_W-1:0] m;
    unique case (code)
      2'd0:    m = {{(FLA_W-8){1'b1}}, 8'h00};
      2'd1:    m = {{(FLA_W-12){1'b1}}, 12'h000};
      2'd2:    m = {{(FLA_W-13){1'b1}}, 13'h0000};
      default: m = {{(FLA_W-16){1'b1}}, 16'h0000};
    endcase
    return m;
  endfunction
endpackage

// File: rtl/flc_data.sv
module flc_data #(
  parameter int NW = 16,
  localparam int IW = $clog2(NW),
  localparam int BI = IW + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_we_i,
  input  logic [IW-1:0] host_widx_i,
  input  logic [31:0]   host_wdata_i,
  input  logic [IW-1:0] host_ridx_i,
  output logic [31:0]   host_rdata_o,
  input  logic          byte_we_i,
  input  logic [BI-1:0] byte_idx_i,
  input  logic [7:0]    byte_wdata_i,
  output logic [7:0]    byte_rdata_o
);
  logic [31:0] words [NW];

  for (genvar w = 0; w < NW; w++) begin : g_word
    logic [31:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_q <= '0;
      end else if (host_we_i && host_widx_i == IW'(w)) begin
        word_q <= host_wdata_i;
      end else if (byte_we_i && byte_idx_i[BI-1:2] == IW'(w)) begin
        for (int b = 0; b < 4; b++) begin
          if (byte_idx_i[1:0] == 2'(b)) word_q[8*b +: 8] <= byte_wdata_i;
        end
      end
    end
    assign words[w] = word_q;
  end

  assign host_rdata_o = words[host_ridx_i];

  logic [31:0] sel_word;
  assign sel_word = words[byte_idx_i[BI-1:2]];

  always_comb begin
    unique case (byte_idx_i[1:0])
      2'd0:    byte_rdata_o = sel_word[7:0];
      2'd1:    byte_rdata_o = sel_word[15:8];
      2'd2:    byte_rdata_o = sel_word[23:16];
      default: byte_rdata_o = sel_word[31:24];
    endcase
  end
endmodule

// File: rtl/flc_regs.sv
module flc_regs import flc_pkg::*; #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic             stat_we_i,
  input  logic             addr_we_i,
  input  logic [31:0]      wdata_i,
  input  logic             busy_i,
  input  logic             fin_i,
  input  logic             fin_err_i,
  input  logic [1:0]       blk_code_i,
  output logic             launch_o,
  output cyc_e             op_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [FLA_W-1:0] fla_o,
  output logic             done_o,
  output logic             err_o,
  output logic [31:0]      ctrl_rd_o,
  output logic [31:0]      stat_rd_o,
  output logic [31:0]      addr_rd_o
);
  cyc_e             op_q;
  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      addr_q;
  logic             done_q, err_q;
  logic             set_done, set_err;

  assign launch_o = ctrl_we_i && wdata_i[GO_BIT] && !busy_i;
  assign set_done = fin_i && !fin_err_i;
  assign set_err  = fin_i && fin_err_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= CYC_READ;
      cnt_q  <= '0;
      addr_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (ctrl_we_i && !busy_i) begin
        op_q  <= cyc_e'(wdata_i[CYC_LSB +: 2]);
        cnt_q <= wdata_i[CNT_LSB +: CNT_W];
      end
      if (addr_we_i && !busy_i) addr_q <= wdata_i;
      // completion wins over a clear in the same cycle
      if (set_done)                            done_q <= 1'b1;
      else if (stat_we_i && wdata_i[DONE_BIT]) done_q <= 1'b0;
      if (set_err)                             err_q <= 1'b1;
      else if (stat_we_i && wdata_i[ERR_BIT])  err_q <= 1'b0;
    end
  end

  assign op_o   = op_q;
  assign cnt_o  = cnt_q;
  assign fla_o  = addr_q[FLA_W-1:0];
  assign done_o = done_q;
  assign err_o  = err_q;

  always_comb begin
    ctrl_rd_o = '0;
    ctrl_rd_o[CYC_LSB +: 2]     = op_q;
    ctrl_rd_o[CNT_LSB +: CNT_W] = cnt_q;
    stat_rd_o = '0;
    stat_rd_o[DONE_BIT]       = done_q;
    stat_rd_o[ERR_BIT]        = err_q;
    stat_rd_o[BUSY_BIT]       = busy_i;
    stat_rd_o[BLK_LSB +: 2]   = blk_code_i;
    addr_rd_o = addr_q;
  end
endmodule

// File: rtl/flc_seq.sv
module flc_seq import flc_pkg::*; #(
  parameter int CNT_W  = 6,
  parameter int PAGE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  cyc_e             op_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [FLA_W-1:0] fla_i,
  input  logic [1:0]       blk_code_i,
  output logic             busy_o,
  output logic             fin_o,
  output logic             fin_err_o,
  output logic [CNT_W-1:0] byte_idx_o,
  output logic             byte_we_o,
  output logic             fl_req_o,
  output logic [1:0]       fl_op_o,
  output logic [FLA_W-1:0] fl_addr_o,
  input  logic             fl_ack_i,
  input  logic             fl_err_i
);
  seq_st_e          st_q, st_d;
  cyc_e             op_q;
  logic [CNT_W-1:0] cnt_q, idx_q;
  logic [FLA_W-1:0] base_q;
  logic [PAGE_W:0]  page_sum;
  logic             page_cross, last_byte, xfer_ack, erase_ack;

  assign page_sum   = {1'b0, op_i == CYC_ERASE ? {PAGE_W{1'b0}} : fla_i[PAGE_W-1:0]}
                    + {{(PAGE_W+1-CNT_W){1'b0}}, cnt_i};
  assign page_cross = page_sum[PAGE_W];
  assign last_byte  = idx_q == cnt_q;
  assign xfer_ack   = st_q == S_XFER && fl_ack_i;
  assign erase_ack  = st_q == S_ERASE && fl_ack_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE: begin
        if (launch_i) begin
          if (op_i == CYC_ERASE)                      st_d = S_ERASE;
          else if (op_i == CYC_RSVD || page_cross)    st_d = S_FAIL;
          else                                        st_d = S_XFER;
        end
      end
      S_XFER:  if (fl_ack_i && (fl_err_i || last_byte)) st_d = S_IDLE;
      S_ERASE: if (fl_ack_i) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      op_q   <= CYC_READ;
      cnt_q  <= '0;
      idx_q  <= '0;
      base_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == S_IDLE && launch_i) begin
        op_q   <= op_i;
        cnt_q  <= cnt_i;
        idx_q  <= '0;
        base_q <= (op_i == CYC_ERASE) ? (fla_i & blk_keep(blk_code_i)) : fla_i;
      end else if (xfer_ack && !last_byte) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign busy_o     = st_q != S_IDLE;
  assign fin_o      = (xfer_ack && (fl_err_i || last_byte)) || erase_ack || st_q == S_FAIL;
  assign fin_err_o  = ((xfer_ack || erase_ack) && fl_err_i) || st_q == S_FAIL;
  assign byte_idx_o = idx_q;
  assign byte_we_o  = xfer_ack && !fl_err_i && op_q == CYC_READ;
  assign fl_req_o   = st_q == S_XFER || st_q == S_ERASE;
  assign fl_op_o    = op_q;
  assign fl_addr_o  = {base_q[FLA_W-1:PAGE_W], base_q[PAGE_W-1:0] + PAGE_W'(idx_q)};
endmodule

// File: rtl/flc_engine.sv
module flc_engine import flc_pkg::*; #(
  parameter int CNT_W  = 6,
  parameter int PAGE_W = 8,
  localparam int NW     = (1 << CNT_W) / 4,
  localparam int IW     = $clog2(NW),
  localparam int ADDR_W = $clog2(DATA_OFF + NW)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [1:0]        blk_code_i,
  output logic              fl_req_o,
  output logic [1:0]        fl_op_o,
  output logic [FLA_W-1:0]  fl_addr_o,
  output logic [7:0]        fl_wdata_o,
  input  logic              fl_ack_i,
  input  logic [7:0]        fl_rdata_i,
  input  logic              fl_err_i
);
  logic             busy, fin, fin_err, launch, done_flag, err_flag;
  logic             ctrl_hit, stat_hit, addr_hit, data_hit;
  logic [IW-1:0]    data_idx;
  cyc_e             op;
  logic [CNT_W-1:0] cnt, byte_idx;
  logic [FLA_W-1:0] fla;
  logic             byte_we;
  logic [31:0]      ctrl_rd, stat_rd, addr_rd, data_rd;

  assign ctrl_hit = reg_addr_i == ADDR_W'(CTRL_OFF);
  assign stat_hit = reg_addr_i == ADDR_W'(STAT_OFF);
  assign addr_hit = reg_addr_i == ADDR_W'(ADDR_OFF);
  assign data_hit = reg_addr_i >= ADDR_W'(DATA_OFF) && reg_addr_i < ADDR_W'(DATA_OFF + NW);
  assign data_idx = IW'(reg_addr_i - ADDR_W'(DATA_OFF));

  flc_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni,
    .ctrl_we_i (reg_we_i && ctrl_hit),
    .stat_we_i (reg_we_i && stat_hit),
    .addr_we_i (reg_we_i && addr_hit),
    .wdata_i   (reg_wdata_i),
    .busy_i    (busy),
    .fin_i     (fin),
    .fin_err_i (fin_err),
    .blk_code_i,
    .launch_o  (launch),
    .op_o      (op),
    .cnt_o     (cnt),
    .fla_o     (fla),
    .done_o    (done_flag),
    .err_o     (err_flag),
    .ctrl_rd_o (ctrl_rd),
    .stat_rd_o (stat_rd),
    .addr_rd_o (addr_rd)
  );

  // launch uses the fields being written, not the stored ones
  flc_seq #(.CNT_W(CNT_W), .PAGE_W(PAGE_W)) u_seq (
    .clk_i, .rst_ni,
    .launch_i   (launch),
    .op_i       (cyc_e'(reg_wdata_i[CYC_LSB +: 2])),
    .cnt_i      (reg_wdata_i[CNT_LSB +: CNT_W]),
    .fla_i      (fla),
    .blk_code_i,
    .busy_o     (busy),
    .fin_o      (fin),
    .fin_err_o  (fin_err),
    .byte_idx_o (byte_idx),
    .byte_we_o  (byte_we),
    .fl_req_o, .fl_op_o, .fl_addr_o,
    .fl_ack_i, .fl_err_i
  );

  flc_data #(.NW(NW)) u_data (
    .clk_i, .rst_ni,
    .host_we_i    (reg_we_i && data_hit && !busy),
    .host_widx_i  (data_idx),
    .host_wdata_i (reg_wdata_i),
    .host_ridx_i  (data_idx),
    .host_rdata_o (data_rd),
    .byte_we_i    (byte_we),
    .byte_idx_i   (byte_idx),
    .byte_wdata_i (fl_rdata_i),
    .byte_rdata_o (fl_wdata_o)
  );

  always_comb begin
    if (ctrl_hit)      reg_rdata_o = ctrl_rd;
    else if (stat_hit) reg_rdata_o = stat_rd;
    else if (addr_hit) reg_rdata_o = addr_rd;
    else if (data_hit) reg_rdata_o = data_rd;
    else               reg_rdata_o = '0;
  end

  // control readback marks the stored fields; unused here but kept for the checker
  logic unused_ok;
  assign unused_ok = ^{op, cnt};
endmodule

// File: rtl/flc_engine_chk.sv
module flc_engine_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              reg_we_i,
  input logic [31:0]       reg_wdata_i,
  input logic [1:0]        blk_code_i,
  input logic              fl_req_o,
  input logic [1:0]        fl_op_o,
  input logic [24:0]       fl_addr_o,
  input logic              fl_ack_i,
  input logic              busy,
  input logic              done_flag,
  input logic              err_flag,
  input logic [31:0]       ctrl_rd,
  input logic [31:0]       addr_rd
);
  logic [24:0] low_bits;
  always_comb begin
    unique case (blk_code_i)
      2'd0:    low_bits = 25'h00000ff;
      2'd1:    low_bits = 25'h0000fff;
      2'd2:    low_bits = 25'h0001fff;
      default: low_bits = 25'h000ffff;
    endcase
  end

  assert_req_in_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_req_o |-> busy);

  assert_req_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_req_o && !fl_ack_i |=> fl_req_o && $stable(fl_addr_o) && $stable(fl_op_o));

  assert_erase_align_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_req_o && fl_op_o == 2'd3 |-> (fl_addr_o & low_bits) == 25'h0);

  assert_flags_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($rose(done_flag) && $rose(err_flag)));

  assert_done_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_flag && !(reg_we_i && reg_addr_i == ADDR_W'(1) && reg_wdata_i[0]) |=> done_flag);

  assert_err_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_flag && !(reg_we_i && reg_addr_i == ADDR_W'(1) && reg_wdata_i[1]) |=> err_flag);

  assert_ctrl_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(ctrl_rd));

  assert_page_stay_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_req_o && fl_op_o != 2'd3 |=> !fl_req_o || fl_addr_o[24:8] == $past(fl_addr_o[24:8]));

  assert_addr_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(addr_rd));
endmodule

bind flc_engine flc_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_addr_i  (reg_addr_i),
  .reg_we_i    (reg_we_i),
  .reg_wdata_i (reg_wdata_i),
  .blk_code_i  (blk_code_i),
  .fl_req_o    (fl_req_o),
  .fl_op_o     (fl_op_o),
  .fl_addr_o   (fl_addr_o),
  .fl_ack_i    (fl_ack_i),
  .busy        (busy),
  .done_flag   (done_flag),
  .err_flag    (err_flag),
  .ctrl_rd     (ctrl_rd),
  .addr_rd     (addr_rd)
);

// File: tb/flc_engine_tb.sv
module flc_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  blk_code = 2'd1;
  logic        fl_req, fl_ack, fl_err;
  logic [1:0]  fl_op;
  logic [24:0] fl_addr;
  logic [7:0]  fl_wdata, fl_rdata;

  int tests = 0, fails = 0;
  bit tb_done = 1'b0;

  always #10 clk = ~clk;

  flc_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_addr_i(reg_addr), .reg_we_i(reg_we), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .blk_code_i(blk_code),
    .fl_req_o(fl_req), .fl_op_o(fl_op), .fl_addr_o(fl_addr), .fl_wdata_o(fl_wdata),
    .fl_ack_i(fl_ack), .fl_rdata_i(fl_rdata), .fl_err_i(fl_err)
  );

  // flash model: answers one clock after a request, then idles a clock
  logic [7:0]  fm [1024];
  int          req_cnt = 0;
  logic [24:0] last_addr = '0, erase_addr = '0;
  bit          inj_en = 1'b0;
  logic [24:0] inj_addr = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_ack <= 1'b0; fl_err <= 1'b0; fl_rdata <= '0;
    end else if (fl_req && !fl_ack) begin
      fl_ack    <= 1'b1;
      fl_rdata  <= fm[fl_addr[9:0]];
      fl_err    <= inj_en && fl_addr == inj_addr;
      last_addr <= fl_addr;
      req_cnt   <= req_cnt + 1;
      if (fl_op == 2'd2 && !(inj_en && fl_addr == inj_addr)) fm[fl_addr[9:0]] <= fl_wdata;
      if (fl_op == 2'd3) erase_addr <= fl_addr;
    end else begin
      fl_ack <= 1'b0; fl_err <= 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] s;
    int k;
    for (k = 0; k < 2000; k++) begin
      reg_rd(5'd1, s);
      if (!s[2]) break;
    end
    if (k == 2000) chk({tag, " busy never cleared"}, 32'd1, 32'd0);
  endtask

  task automatic clr_flags();
    logic [31:0] s;
    reg_rd(5'd1, s);
    reg_wr(5'd1, s);
  endtask

  function automatic logic [31:0] go_word(input logic [1:0] op, input int len);
    return 32'h1 | (32'(op) << 1) | (32'(len - 1) << 8);
  endfunction

  function automatic logic [31:0] wpat(input int w, input int len);
    return 32'hA0B0C0D0 ^ (32'(w) * 32'h01010101) ^ 32'(len);
  endfunction

  task automatic run(input logic [31:0] fla, input logic [31:0] ctl, input string tag);
    clr_flags();
    reg_wr(5'd2, fla);
    reg_wr(5'd0, ctl);
    wait_idle(tag);
  endtask

  logic [7:0] sh [64];

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!tb_done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] r, s, exp;
    int n0;
    for (int i = 0; i < 1024; i++) fm[i] = 8'((i * 37 + 11) & 255);
    for (int i = 0; i < 64; i++) sh[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    reg_rd(5'd0, r); chk("R1 reset ctrl", r, 32'h0);
    reg_rd(5'd1, r); chk("R5 reset status shows strap", r, 32'h8);
    reg_rd(5'd2, r); chk("R10 reset addr", r, 32'h0);
    reg_rd(5'd4, r); chk("R3 reset data", r, 32'h0);
    chk("R2 reset no request", 32'(fl_req), 32'h0);

    // R1 field readback without go
    reg_wr(5'd0, 32'h0000_2F04);
    reg_rd(5'd0, r); chk("R1 ctrl fields", r, 32'h0000_2F04);
    reg_wr(5'd0, 32'h0000_0A06);
    reg_rd(5'd0, r); chk("R1 ctrl fields 2", r, 32'h0000_0A06);
    reg_rd(5'd1, r); chk("R1 no go no busy", r & 32'h7, 32'h0);

    // R3 read sweep over every length
    for (int len = 1; len <= 64; len++) begin
      logic [24:0] a;
      a = 25'h0200 + 25'(len);
      run({7'h0, a}, go_word(2'd0, len), "R3");
      reg_rd(5'd1, s); chk($sformatf("R6 read len %0d flags", len), s & 32'h3, 32'h1);
      for (int i = 0; i < len; i++) sh[i] = fm[(int'(a) + i) & 1023];
      for (int w = 0; w < (len + 3) / 4; w++) begin
        reg_rd(5'(4 + w), r);
        chk($sformatf("R3 read len %0d word %0d", len, w), r,
            {sh[4*w+3], sh[4*w+2], sh[4*w+1], sh[4*w]});
      end
    end

    // R4 write at several lengths, boundary byte untouched
    begin
      int lens [6] = '{1, 3, 4, 5, 17, 64};
      for (int k = 0; k < 6; k++) begin
        int len;
        logic [24:0] a;
        len = lens[k];
        a = {17'h1_0003, 8'(4 * k)};
        for (int w = 0; w < 16; w++) reg_wr(5'(4 + w), wpat(w, len));
        for (int i = 0; i < 80; i++) fm[(int'(a) + i) & 1023] = 8'h5A;
        run({7'h0, a}, go_word(2'd2, len), "R4");
        reg_rd(5'd1, s); chk($sformatf("R6 write len %0d flags", len), s & 32'h3, 32'h1);
        for (int i = 0; i < len; i++) begin
          exp = wpat(i / 4, len) >> (8 * (i % 4));
          chk($sformatf("R4 write len %0d byte %0d", len, i),
              32'(fm[(int'(a) + i) & 1023]), exp & 32'hFF);
        end
        chk($sformatf("R4 write len %0d past end", len), 32'(fm[(int'(a) + len) & 1023]), 32'h5A);
      end
    end

    // R5 erase for each block code, count field ignored
    for (int c = 0; c < 4; c++) begin
      int sz;
      logic [24:0] a;
      sz = (c == 0) ? 256 : (c == 1) ? 4096 : (c == 2) ? 8192 : 65536;
      a = 25'h1ABCDEF;
      blk_code = 2'(c);
      reg_rd(5'd1, s); chk($sformatf("R5 strap code %0d in status", c), (s >> 3) & 32'h3, 32'(c));
      n0 = req_cnt;
      run({7'h0, a}, 32'h1 | (32'd3 << 1) | (32'h15 << 8), "R5");
      chk($sformatf("R5 erase code %0d address", c), 32'(erase_addr), 32'(a) - (32'(a) % 32'(sz)));
      chk($sformatf("R5 erase code %0d one request", c), 32'(req_cnt - n0), 32'd1);
      reg_rd(5'd1, s); chk($sformatf("R6 erase code %0d flags", c), s & 32'h3, 32'h1);
    end
    blk_code = 2'd1;

    // R12 flash error on third byte of a read
    for (int w = 0; w < 2; w++) reg_wr(5'(4 + w), 32'h1111_1111);
    inj_en = 1'b1; inj_addr = 25'h0282;
    n0 = req_cnt;
    run(32'h0280, go_word(2'd0, 8), "R12");
    inj_en = 1'b0;
    reg_rd(5'd1, s); chk("R12 R6 flash error flags", s & 32'h3, 32'h2);
    chk("R12 stops at failing byte", 32'(req_cnt - n0), 32'd3);
    reg_rd(5'd4, r); chk("R12 failing byte not stored", r, {8'h11, fm[10'h282 - 0] ^ fm[10'h282] ^ 8'h11 ^ 8'h11, fm[10'h281], fm[10'h280]} & 32'hFF00_FFFF | 32'h0011_0000);

    // R7 sticky flags
    run(32'h0200, go_word(2'd0, 1), "R7");
    reg_wr(5'd1, 32'h0);
    reg_rd(5'd1, s); chk("R7 write zero keeps done", s & 32'h3, 32'h1);
    reg_wr(5'd2, 32'h01F0);
    reg_wr(5'd0, go_word(2'd0, 32));
    wait_idle("R7");
    reg_rd(5'd1, s); chk("R7 both flags accumulate", s & 32'h3, 32'h3);
    reg_wr(5'd1, 32'h2);
    reg_rd(5'd1, s); chk("R7 clear error only", s & 32'h3, 32'h1);
    reg_wr(5'd1, 32'h1);
    reg_rd(5'd1, s); chk("R7 clear done", s & 32'h3, 32'h0);
    reg_wr(5'd2, 32'h0200);
    reg_wr(5'd0, go_word(2'd0, 1));
    wait_idle("R7");
    reg_wr(5'd2, 32'h01F0);
    reg_wr(5'd0, go_word(2'd0, 32));
    wait_idle("R7");
    reg_rd(5'd1, s); reg_wr(5'd1, s);
    reg_rd(5'd1, s); chk("R7 write back clears all", s & 32'h3, 32'h0);

    // R8 and R2: writes during a long write cycle are ignored
    for (int w = 0; w < 16; w++) reg_wr(5'(4 + w), wpat(w, 99));
    clr_flags();
    reg_wr(5'd2, 32'h0340);
    n0 = req_cnt;
    reg_wr(5'd0, go_word(2'd2, 64));
    reg_rd(5'd1, s); chk("R2 busy after go", (s >> 2) & 32'h1, 32'h1);
    reg_wr(5'd0, go_word(2'd0, 4));
    reg_wr(5'd2, 32'h0123);
    reg_wr(5'd4, 32'hDEADBEEF);
    wait_idle("R8");
    reg_rd(5'd0, r); chk("R8 ctrl unchanged", r, go_word(2'd2, 64) & ~32'h1);
    reg_rd(5'd2, r); chk("R8 addr unchanged", r, 32'h0340);
    reg_rd(5'd4, r); chk("R8 data unchanged", r, wpat(0, 99));
    chk("R8 no second cycle", 32'(req_cnt - n0), 32'd64);
    chk("R8 first byte written", 32'(fm[10'h340]), wpat(0, 99) & 32'hFF);
    reg_rd(5'd1, s); chk("R2 R6 done after cycle", s & 32'h7, 32'h1);

    // R9 page boundary
    n0 = req_cnt;
    run(32'h05F0, go_word(2'd0, 17), "R9");
    reg_rd(5'd1, s); chk("R9 read crossing page flags", s & 32'h3, 32'h2);
    chk("R9 read crossing no request", 32'(req_cnt - n0), 32'd0);
    run(32'h05F1, go_word(2'd2, 16), "R9");
    reg_rd(5'd1, s); chk("R9 write crossing page flags", s & 32'h3, 32'h2);
    chk("R9 write crossing no request", 32'(req_cnt - n0), 32'd0);
    run(32'h05F0, go_word(2'd0, 16), "R9");
    reg_rd(5'd1, s); chk("R9 ends on last page byte flags", s & 32'h3, 32'h1);
    chk("R9 ends on last page byte requests", 32'(req_cnt - n0), 32'd16);
    chk("R9 last address", 32'(last_addr), 32'h05FF);

    // R11 reserved code
    n0 = req_cnt;
    run(32'h0200, go_word(2'd1, 4), "R11");
    reg_rd(5'd1, s); chk("R11 reserved code flags", s & 32'h3, 32'h2);
    chk("R11 reserved code no request", 32'(req_cnt - n0), 32'd0);

    // R10 upper address bits
    run(32'hFE00_0405, go_word(2'd0, 4), "R10");
    reg_rd(5'd2, r); chk("R10 upper bits kept", r, 32'hFE00_0405);
    chk("R10 flash sees 25 bits", 32'(last_addr), 32'h0408);
    reg_rd(5'd4, r); chk("R10 R3 data from low address", r,
                         {fm[10'h008], fm[10'h007], fm[10'h006], fm[10'h005]});

    tb_done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule